// File: doc/BRIEF.md
# Dual-Lane Synchronous Serial Port

This block is a synchronous serial port with two data lanes, lane 0 (primary) and lane 1 (secondary). Both lanes share one serial bit clock and one frame sync. A single direction input makes both lanes transmitters or both lanes receivers. The datapath of the direction not selected freezes completely: it ignores the serial clock and the frame sync, and it ignores host traffic.

In transmit mode, the host writes words into a per-lane holding register. At each frame start the word moves into the lane's shift register and is sent MSB first. In receive mode, each lane shifts bits in and places every completed word into a per-lane receive buffer for the host to read. The host sees a request/ready handshake. A request that cannot be served keeps ready low for as long as the request is held, with no timeout.

The serial clock, frame sync, data inputs and slot gate are sampled in the system clock domain. They must already be synchronous to `clk`, and each serial clock level must last at least one `clk` cycle.

Top module: `duo_serial_port`

## Requirements
- R1: With `cfg_tx`=1 the receive state (`rx_valid`, `rx_oflow`) never changes. With `cfg_tx`=0 the transmit state (`tx_nfull`, `tx_uflow`) never changes, whatever the serial and host inputs do.
- R2: `doe[i]` is 1 exactly when `cfg_tx`=1, `cfg_en[i]`=1 and `slot_off`=0. A lane with `cfg_en[i]`=0 never drives and never captures a word. Index 0 is lane A and index 1 is lane B.
- R3: Each transmit lane buffers two words: the holding register plus the shift register. `tx_nfull[i]` is 0 while the holding register is full. A write to a full holding register stalls until a frame start empties it.
- R4: Frame sync is sampled on each serial clock falling edge. On the next rising edge the transmit lane loads its holding word and drives its MSB. Each later rising edge drives the next lower bit until all bits are out. After that the output keeps the last bit.
- R5: A receiving lane samples data on falling edges. It takes the MSB on the falling edge after the one where frame sync was seen, then one bit per falling edge. After the last bit the word is placed right-aligned and zero-filled in the lane's buffer, and `rx_valid[i]` is set. A read clears `rx_valid[i]`.
- R6: A word has `cfg_wlen`+1 bits. `cfg_wlen` values 0 and 1 act as 2, so the shortest word has 3 bits.
- R7: A frame start with an empty holding register re-sends the lane's previous word (zero after reset) and sets the sticky `tx_uflow[i]`.
- R8: A word that completes while `rx_valid[i]` is 1 and no read is accepted in that cycle is dropped. The buffer keeps the old word, and the sticky `rx_oflow[i]` is set.
- R9: `host_ready` is 0 for every write while `cfg_tx`=0, for every read while `cfg_tx`=1, and for every read of an empty buffer. It stays 0 for as long as the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_tx | input | 1 | Direction: 1 transmit on both lanes, 0 receive on both lanes |
| cfg_en | input | 2 | Per-lane enable (bit 0 lane A, bit 1 lane B) |
| cfg_wlen | input | 5 | Word length minus one |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| fsync | input | 1 | Frame sync, sampled on serial clock falling edges |
| slot_off | input | 1 | Inactive time slot: releases both transmit outputs |
| din | input | 2 | Serial data in, one bit per lane |
| dout | output | 2 | Serial data out, one bit per lane |
| doe | output | 2 | Output enable for the lane pad drivers |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_we | input | 1 | 1 write a transmit holding register, 0 read a receive buffer |
| host_sel | input | 1 | Lane select, 0 lane A, 1 lane B |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected receive buffer |
| host_ready | output | 1 | Access completes in a cycle where this is 1 |
| tx_nfull | output | 2 | Holding register of each lane can take a word |
| rx_valid | output | 2 | Receive buffer of each lane holds a word |
| tx_uflow | output | 2 | Sticky transmit underflow per lane |
| rx_oflow | output | 2 | Sticky receive overflow per lane |

## Verification
A bad holding-register flag shows at once on `tx_nfull` and `host_ready`. A wrong transmit bit counter or a wrongly loaded shift word shows on `dout` one system clock after the next serial rising edge. Wrong receive shifting state first shows when the word completes, through `rx_valid` or the flags, and shows in value only when the word is read out. The sticky flags and the stall rule show in the same cycle as the cause, because the bench compares every output on every clock.

// File: rtl/duo_sp_pkg.sv
package duo_sp_pkg;
  localparam int unsigned NCH      = 2;
  localparam int unsigned SELW     = $clog2(NCH);
  localparam int unsigned MIN_BITS = 3;

  typedef enum logic { DIR_RX = 1'b0, DIR_TX = 1'b1 } dir_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } sedge_t;
endpackage

// File: rtl/duo_sp_edge.sv
module duo_sp_edge
  import duo_sp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk,
  output sedge_t ev
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_comb begin
    ev.rise = sclk & ~sclk_q;
    ev.fall = ~sclk & sclk_q;
  end
endmodule

// File: rtl/duo_sp_txlane.sv
module duo_sp_txlane
  import duo_sp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  sedge_t        ev,
  input  logic          fsync,
  input  logic [LW-1:0] wl,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          hold_full,
  output logic          bit_o,
  output logic          uflow
);
  logic [DW-1:0] hold_q, hold_d, cur_q, cur_d;
  logic          hfull_q, hfull_d, pend_q, pend_d, busy_q, busy_d;
  logic          bit_q, bit_d, uf_q, uf_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          ce;

  assign ce = (act & (ev.rise | ev.fall)) | wr_en;

  always_comb begin
    hold_d  = hold_q;
    cur_d   = cur_q;
    hfull_d = hfull_q;
    pend_d  = pend_q;
    busy_d  = busy_q;
    bit_d   = bit_q;
    uf_d    = uf_q;
    cnt_d   = cnt_q;
    if (act && ev.fall && fsync) pend_d = 1'b1;
    if (act && ev.rise) begin
      if (pend_q) begin
        pend_d = 1'b0;
        busy_d = 1'b1;
        cnt_d  = wl;
        if (hfull_q) begin
          cur_d   = hold_q;
          hfull_d = 1'b0;
          bit_d   = hold_q[wl];
        end else begin
          uf_d  = 1'b1;
          bit_d = cur_q[wl];
        end
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
          bit_d = cur_q[cnt_q - 1'b1];
        end
      end
    end
    if (wr_en) begin
      hold_d  = wr_data;
      hfull_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      cur_q   <= '0;
      hfull_q <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      bit_q   <= 1'b0;
      uf_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (ce) begin
      hold_q  <= hold_d;
      cur_q   <= cur_d;
      hfull_q <= hfull_d;
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      uf_q    <= uf_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold_full = hfull_q;
  assign bit_o     = bit_q;
  assign uflow     = uf_q;
endmodule

// File: rtl/duo_sp_rxlane.sv
module duo_sp_rxlane
  import duo_sp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  sedge_t        ev,
  input  logic          fsync,
  input  logic          din,
  input  logic [LW-1:0] wl,
  input  logic          rd_en,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          oflow
);
  logic [DW-2:0] sh_q, sh_d;
  logic [DW-1:0] buf_q, buf_d, word;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, val_q, val_d, of_q, of_d;
  logic          done, ce;

  assign word = {sh_q, din};
  assign ce   = (act & ev.fall) | rd_en;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (act && ev.fall) begin
      if (busy_q) begin
        sh_d = word[DW-2:0];
        if (cnt_q == wl) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (fsync) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        sh_d   = '0;
      end
    end
  end

  always_comb begin
    buf_d = buf_q;
    val_d = val_q;
    of_d  = of_q;
    if (rd_en) val_d = 1'b0;
    if (done) begin
      if (val_q && !rd_en) begin
        of_d = 1'b1;
      end else begin
        buf_d = word;
        val_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      val_q  <= 1'b0;
      of_q   <= 1'b0;
    end else if (ce) begin
      sh_q   <= sh_d;
      buf_q  <= buf_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      val_q  <= val_d;
      of_q   <= of_d;
    end
  end

  assign valid = val_q;
  assign data  = buf_q;
  assign oflow = of_q;
endmodule

// File: rtl/duo_serial_port.sv
module duo_serial_port
  import duo_sp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_tx,
  input  logic [NCH-1:0]  cfg_en,
  input  logic [LW-1:0]   cfg_wlen,
  input  logic            sclk,
  input  logic            fsync,
  input  logic            slot_off,
  input  logic [NCH-1:0]  din,
  output logic [NCH-1:0]  dout,
  output logic [NCH-1:0]  doe,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [SELW-1:0] host_sel,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_ready,
  output logic [NCH-1:0]  tx_nfull,
  output logic [NCH-1:0]  rx_valid,
  output logic [NCH-1:0]  tx_uflow,
  output logic [NCH-1:0]  rx_oflow
);
  localparam logic [LW-1:0] WL_MIN = LW'(MIN_BITS - 1);

  logic [1:0]     rst_sync_q;
  logic           rst_i_n;
  sedge_t         ev;
  dir_e           dir;
  logic [LW-1:0]  wl_eff;
  logic [NCH-1:0] hfull, rvalid;
  logic [DW-1:0]  rxd [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign dir    = dir_e'(cfg_tx);
  assign wl_eff = (cfg_wlen < WL_MIN) ? WL_MIN : cfg_wlen;

  duo_sp_edge u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .sclk  (sclk),
    .ev    (ev)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic tx_act, rx_act, wr_en, rd_en, hit;

    assign hit    = (host_sel == SELW'(c));
    assign tx_act = (dir == DIR_TX) & cfg_en[c];
    assign rx_act = (dir == DIR_RX) & cfg_en[c];
    assign wr_en  = host_req & host_we & hit & (dir == DIR_TX) & ~hfull[c];
    assign rd_en  = host_req & ~host_we & hit & (dir == DIR_RX) & rvalid[c];
    assign doe[c] = (dir == DIR_TX) & cfg_en[c] & ~slot_off;

    duo_sp_txlane #(.DW(DW), .LW(LW)) u_tx (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .act       (tx_act),
      .ev        (ev),
      .fsync     (fsync),
      .wl        (wl_eff),
      .wr_en     (wr_en),
      .wr_data   (host_wdata),
      .hold_full (hfull[c]),
      .bit_o     (dout[c]),
      .uflow     (tx_uflow[c])
    );

    duo_sp_rxlane #(.DW(DW), .LW(LW)) u_rx (
      .clk   (clk),
      .rst_n (rst_i_n),
      .act   (rx_act),
      .ev    (ev),
      .fsync (fsync),
      .din   (din[c]),
      .wl    (wl_eff),
      .rd_en (rd_en),
      .valid (rvalid[c]),
      .data  (rxd[c]),
      .oflow (rx_oflow[c])
    );
  end

  assign tx_nfull   = ~hfull;
  assign rx_valid   = rvalid;
  assign host_rdata = rxd[host_sel];
  assign host_ready = host_req & (host_we ? ((dir == DIR_TX) & ~hfull[host_sel])
                                          : ((dir == DIR_RX) & rvalid[host_sel]));
endmodule

// File: rtl/duo_serial_port_chk.sv
module duo_serial_port_chk
  import duo_sp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_tx,
  input logic            slot_off,
  input logic [NCH-1:0]  doe,
  input logic            host_req,
  input logic            host_we,
  input logic [SELW-1:0] host_sel,
  input logic            host_ready,
  input logic [NCH-1:0]  tx_nfull,
  input logic [NCH-1:0]  rx_valid,
  input logic [NCH-1:0]  tx_uflow,
  input logic [NCH-1:0]  rx_oflow
);
  p_txside_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_tx && $past(!cfg_tx)) |-> ($stable(tx_nfull) && $stable(tx_uflow)));

  p_rxside_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx && $past(cfg_tx)) |-> ($stable(rx_valid) && $stable(rx_oflow)));

  p_slot_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_off || !cfg_tx) |-> (doe == '0));

  p_write_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && !cfg_tx) |-> !host_ready);

  p_read_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && cfg_tx) |-> !host_ready);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    p_rx_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[c] && !(host_req && !host_we && host_sel == SELW'(c))) |=> rx_valid[c]);

    p_uflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_uflow[c] |=> tx_uflow[c]);

    p_oflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_oflow[c] |=> rx_oflow[c]);
  end
endmodule

bind duo_serial_port duo_serial_port_chk u_chk (.*);

// File: tb/duo_serial_port_test.sv
`timescale 1ns/1ps
module duo_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_tx;
  logic [1:0]  cfg_en;
  logic [4:0]  cfg_wlen;
  logic        sclk, fsync, slot_off;
  logic [1:0]  din, dout, doe;
  logic        host_req, host_we, host_sel;
  logic [31:0] host_wdata, host_rdata;
  logic        host_ready;
  logic [1:0]  tx_nfull, rx_valid, tx_uflow, rx_oflow;

  int nchk = 0, nerr = 0;
  bit cmp_on = 0, fin = 0;

  always #2.5 clk = ~clk;

  duo_serial_port uut (.*);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic        m_sprev;
  bit          m_hfull[2], m_pend[2], m_tbusy[2], m_uf[2];
  bit          m_rbusy[2], m_rv[2], m_of[2];
  logic        m_dout[2];
  logic [31:0] m_hold[2], m_cur[2], m_sh[2], m_buf[2];
  int          m_tidx[2], m_ridx[2];

  function automatic bit mready();
    if (!host_req) return 0;
    if (host_we) return cfg_tx && !m_hfull[host_sel];
    return !cfg_tx && m_rv[host_sel];
  endfunction

  bit rise, fall, acc, rdone;
  int n;
  logic [31:0] rword;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sprev = 0;
      for (int c = 0; c < 2; c++) begin
        m_hfull[c] = 0; m_pend[c] = 0; m_tbusy[c] = 0; m_uf[c] = 0;
        m_rbusy[c] = 0; m_rv[c] = 0; m_of[c] = 0; m_dout[c] = 0;
        m_hold[c] = 0; m_cur[c] = 0; m_sh[c] = 0; m_buf[c] = 0;
        m_tidx[c] = 0; m_ridx[c] = 0;
      end
    end else begin
      rise = sclk && !m_sprev;
      fall = !sclk && m_sprev;
      m_sprev = sclk;
      acc = mready();
      n = ((cfg_wlen < 2) ? 2 : int'(cfg_wlen)) + 1;
      for (int c = 0; c < 2; c++) begin
        if (cfg_tx && cfg_en[c]) begin
          if (fall && fsync) m_pend[c] = 1;
          if (rise) begin
            if (m_pend[c]) begin
              m_pend[c] = 0;
              if (m_hfull[c]) begin m_cur[c] = m_hold[c]; m_hfull[c] = 0; end
              else m_uf[c] = 1;
              m_tbusy[c] = 1; m_tidx[c] = n - 1; m_dout[c] = m_cur[c][n-1];
            end else if (m_tbusy[c]) begin
              if (m_tidx[c] == 0) m_tbusy[c] = 0;
              else begin m_tidx[c]--; m_dout[c] = m_cur[c][m_tidx[c]]; end
            end
          end
        end
        rdone = 0;
        if (!cfg_tx && cfg_en[c] && fall) begin
          if (m_rbusy[c]) begin
            rword = (m_sh[c] << 1) | 32'(din[c]);
            m_sh[c] = rword;
            if (m_ridx[c] == n - 1) begin rdone = 1; m_rbusy[c] = 0; end
            else m_ridx[c]++;
          end
          if (fsync) begin m_rbusy[c] = 1; m_ridx[c] = 0; m_sh[c] = 0; end
        end
        if (acc && !host_we && host_sel == c[0]) m_rv[c] = 0;
        if (rdone) begin
          if (m_rv[c]) m_of[c] = 1;
          else begin m_buf[c] = rword; m_rv[c] = 1; end
        end
        if (acc && host_we && host_sel == c[0]) begin
          m_hold[c] = host_wdata; m_hfull[c] = 1;
        end
      end
    end
  end

  // per-clock comparison with the model
  bit exp_oe;
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      for (int c = 0; c < 2; c++) begin
        exp_oe = cfg_tx && cfg_en[c] && !slot_off;
        check(doe[c] === exp_oe, "R2", "doe", 32'(doe[c]), 32'(exp_oe));
        if (exp_oe) check(dout[c] === m_dout[c], "R4", "dout", 32'(dout[c]), 32'(m_dout[c]));
        check(tx_nfull[c] === !m_hfull[c], "R3", "tx_nfull", 32'(tx_nfull[c]), 32'(!m_hfull[c]));
        check(rx_valid[c] === m_rv[c], "R5", "rx_valid", 32'(rx_valid[c]), 32'(m_rv[c]));
        check(tx_uflow[c] === m_uf[c], "R7", "tx_uflow", 32'(tx_uflow[c]), 32'(m_uf[c]));
        check(rx_oflow[c] === m_of[c], "R8", "rx_oflow", 32'(rx_oflow[c]), 32'(m_of[c]));
      end
      check(host_ready === mready(), "R9", "host_ready", 32'(host_ready), 32'(mready()));
      if (host_req && !host_we && host_ready)
        check(host_rdata === m_buf[host_sel], "R5", "host_rdata", host_rdata, m_buf[host_sel]);
    end
  end

  task automatic frame(input int nb, input logic [31:0] wa, input logic [31:0] wb,
                       output logic [31:0] ga, output logic [31:0] gb);
    ga = 0; gb = 0;
    for (int p = 0; p <= nb; p++) begin
      @(negedge clk);
      sclk = 1; fsync = (p == 0);
      din[0] = (p > 0) ? wa[nb-p] : 1'b0;
      din[1] = (p > 0) ? wb[nb-p] : 1'b0;
      @(negedge clk); @(negedge clk);
      if (p > 0) begin ga = {ga[30:0], dout[0]}; gb = {gb[30:0], dout[1]}; end
      sclk = 0;
      @(negedge clk);
    end
    @(negedge clk); sclk = 1; fsync = 0; din = 2'b00;
    @(negedge clk); @(negedge clk); sclk = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic hwrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_sel = sel; host_wdata = d;
    #1;
    while (!host_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic hread(input logic sel, output logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_sel = sel;
    #1;
    while (!host_ready) begin @(negedge clk); #1; end
    d = host_rdata;
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic stall(input logic sel, input logic we, input int cyc, input string rq);
    @(negedge clk);
    host_req = 1; host_we = we; host_sel = sel; host_wdata = 32'hDEAD_0000;
    for (int i = 0; i < cyc; i++) begin
      #1;
      check(host_ready === 1'b0, rq, "stalled request ready", 32'(host_ready), 32'd0);
      @(negedge clk);
    end
    host_req = 0;
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    logic [31:0] ga, gb, rd;
    rst_n = 0; cfg_tx = 0; cfg_en = 2'b11; cfg_wlen = 5'd7;
    sclk = 0; fsync = 0; slot_off = 0; din = 2'b00;
    host_req = 0; host_we = 0; host_sel = 0; host_wdata = 0;
    settle(5);
    rst_n = 1;
    settle(4);
    cmp_on = 1;
    // reset state
    check(tx_nfull === 2'b11, "R3", "reset tx_nfull", 32'(tx_nfull), 32'h3);
    check(rx_valid === 2'b00, "R5", "reset rx_valid", 32'(rx_valid), 32'h0);
    check({tx_uflow, rx_oflow} === 4'b0, "R7", "reset flags", 32'({tx_uflow, rx_oflow}), 32'h0);
    check(doe === 2'b00, "R2", "reset doe in receive mode", 32'(doe), 32'h0);

    // transmit, 8-bit words
    cfg_tx = 1; settle(2);
    check(doe === 2'b11, "R2", "doe in transmit", 32'(doe), 32'h3);
    hwrite(0, 32'hA5);
    check(tx_nfull === 2'b10, "R3", "lane A holding full", 32'(tx_nfull), 32'h2);
    hwrite(1, 32'h3C);
    stall(0, 1, 6, "R3");
    frame(8, 0, 0, ga, gb);
    check(ga === 32'hA5, "R4", "lane A serial word", ga, 32'hA5);
    check(gb === 32'h3C, "R4", "lane B serial word", gb, 32'h3C);
    check(tx_nfull === 2'b11, "R3", "holding emptied at frame start", 32'(tx_nfull), 32'h3);
    check(tx_uflow === 2'b00, "R7", "no underflow yet", 32'(tx_uflow), 32'h0);

    // underflow repeats previous word
    frame(8, 0, 0, ga, gb);
    check(ga === 32'hA5, "R7", "lane A repeat", ga, 32'hA5);
    check(gb === 32'h3C, "R7", "lane B repeat", gb, 32'h3C);
    check(tx_uflow === 2'b11, "R7", "underflow sticky", 32'(tx_uflow), 32'h3);

    // 16-bit words
    cfg_wlen = 5'd15;
    hwrite(0, 32'hBEEF);
    frame(16, 0, 0, ga, gb);
    check(ga === 32'hBEEF, "R6", "16-bit lane A word", ga, 32'hBEEF);
    check(gb === 32'h003C, "R7", "16-bit lane B repeat", gb, 32'h003C);

    // slot gate and enable
    slot_off = 1; settle(2);
    check(doe === 2'b00, "R2", "inactive slot releases pins", 32'(doe), 32'h0);
    slot_off = 0; cfg_en = 2'b01; settle(2);
    check(doe === 2'b01, "R2", "disabled lane B not driven", 32'(doe), 32'h1);
    cfg_en = 2'b11;

    stall(0, 0, 8, "R9");

    // receive, 12-bit words
    cfg_tx = 0; cfg_wlen = 5'd11; settle(2);
    check(doe === 2'b00, "R1", "receive mode drives nothing", 32'(doe), 32'h0);
    stall(1, 1, 6, "R9");
    check(tx_nfull === 2'b11, "R1", "transmit side untouched", 32'(tx_nfull), 32'h3);
    frame(12, 32'hABC, 32'h5A5, ga, gb);
    check(rx_valid === 2'b11, "R5", "both words valid", 32'(rx_valid), 32'h3);
    hread(0, rd); check(rd === 32'hABC, "R5", "lane A word", rd, 32'hABC);
    hread(1, rd); check(rd === 32'h5A5, "R5", "lane B word", rd, 32'h5A5);
    check(rx_valid === 2'b00, "R5", "valid cleared by read", 32'(rx_valid), 32'h0);
    stall(0, 0, 6, "R9");

    // overflow
    frame(12, 32'h123, 32'h456, ga, gb);
    frame(12, 32'h777, 32'h888, ga, gb);
    check(rx_oflow === 2'b11, "R8", "overflow sticky", 32'(rx_oflow), 32'h3);
    hread(0, rd); check(rd === 32'h123, "R8", "lane A keeps old word", rd, 32'h123);
    hread(1, rd); check(rd === 32'h456, "R8", "lane B keeps old word", rd, 32'h456);

    // shortest word
    cfg_wlen = 5'd0;
    frame(3, 32'h5, 32'h2, ga, gb);
    hread(0, rd); check(rd === 32'h5, "R6", "3-bit lane A", rd, 32'h5);
    hread(1, rd); check(rd === 32'h2, "R6", "3-bit lane B", rd, 32'h2);

    // disabled lane captures nothing
    cfg_en = 2'b01;
    frame(3, 32'h3, 32'h7, ga, gb);
    check(rx_valid === 2'b01, "R2", "disabled lane B no capture", 32'(rx_valid), 32'h1);
    hread(0, rd); check(rd === 32'h3, "R5", "lane A while B off", rd, 32'h3);
    cfg_en = 2'b11;

    // receive side frozen in transmit mode
    cfg_tx = 1; settle(2);
    frame(3, 32'h7, 32'h7, ga, gb);
    check(rx_valid === 2'b00, "R1", "no capture in transmit", 32'(rx_valid), 32'h0);
    check(rx_oflow === 2'b11, "R1", "receive flags untouched", 32'(rx_oflow), 32'h3);

    settle(4);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule